// File: doc/BRIEF.md
# Three-Wire Latched Configuration Receiver

This block is the write-only serial configuration port of a two-channel frequency synthesizer. A host drives a serial clock, a data line and a load strobe. The data line is sampled on each rising serial-clock edge into a 22-bit input register, and the newest bit enters at the least significant end. A host that sends three bytes (24 clocks) therefore loses its first two bits off the top. When the strobe rises, the input register is copied into one of four configuration latches. Each channel has a reference-divider latch and a main-divider latch.

The two least significant bits of the word select the target latch. Bit 0 chooses between the reference latch (0) and the main latch (1). Bit 1 chooses the channel. Each channel's active output stays low until both of that channel's latches have been written since reset. The three serial inputs are asynchronous to the system clock. They are synchronized and edge-detected in the system clock domain, which must run at least four times faster than the serial clock.

Top module: `cfg_serial_rx`

## Requirements
- R1: While reset is applied and after it is released, all four latch outputs read zero and both channel-active outputs are low, until a valid transfer occurs.
- R2: The data line is shifted in on rising serial-clock edges only. The earliest bit sent ends up nearest the top of the word, and the last bit sent is bit 0.
- R3: When more than 22 bits are clocked in before a strobe, only the newest 22 bits are kept. For a 24-clock transfer, the first two bits are discarded.
- R4: A rising strobe edge copies the 22-bit input register into the latch chosen by word bits [1:0]: 00 selects channel 0 reference, 01 selects channel 0 main, 10 selects channel 1 reference, and 11 selects channel 1 main.
- R5: A transfer leaves the three unselected latches unchanged, and latches never change without a strobe rising edge.
- R6: A channel's active output goes high once both of its latches have been written since reset, and it stays high until the next reset. A channel with only one latch written stays inactive.
- R7: A strobe rising edge with no serial-clock rising edge since the previous strobe rising edge is ignored. It changes no latch and no active output.
- R8: The input register is not cleared by a transfer. A transfer of fewer than 22 new bits uses the older bits shifted up, so that N new bits give {previous word[21-N:0], new bits}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data_i | input | 1 | Serial data line |
| ser_strobe_i | input | 1 | Load strobe; its rising edge transfers the word |
| ref_latch_o | output | 44 | Reference latches, channel c at bits [22c+21:22c] |
| main_latch_o | output | 44 | Main latches, channel c at bits [22c+21:22c] |
| chan_active_o | output | 2 | Per-channel active flag |

## Verification
The assertions assume that a synchronized serial-clock rising edge and a strobe rising edge never fall in the same system cycle. They also assume that the data line is stable for several system cycles around each rising serial-clock edge. The stimulus holds every serial-clock and strobe level for at least three system cycles. It changes data three cycles before raising the serial clock and keeps the strobe low while shifting, so both assumptions hold throughout. Checks are sampled well after the three-register synchronizer and edge-detect latency has elapsed.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam int unsigned CFG_WORD_W   = 22;
  localparam int unsigned CFG_CHANNELS = 2;
  localparam int unsigned CFG_SYNC_STG = 2;

  // Target latch kind carried in word bit 0
  typedef enum logic {
    LATCH_REF  = 1'b0,
    LATCH_MAIN = 1'b1
  } latch_kind_e;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              hist_q, hist_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = async_i;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_comb hist_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~hist_q;
endmodule

// File: rtl/shift_capture.sv
module shift_capture #(
  parameter int unsigned WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic              strobe_rise_i,
  output logic [WORD_W-1:0] word_o,
  output logic              have_bits_o,
  output logic              commit_o
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              have_q, have_d;
  logic              commit;

  always_comb begin
    commit = strobe_rise_i & have_q;
    word_d = word_q;
    have_d = have_q;
    if (shift_en_i) begin
      word_d = {word_q[WORD_W-2:0], bit_i};
      have_d = 1'b1;
    end else if (commit) begin
      have_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      have_q <= 1'b0;
    end else begin
      word_q <= word_d;
      have_q <= have_d;
    end
  end

  assign word_o      = word_q;
  assign have_bits_o = have_q;
  assign commit_o    = commit;
endmodule

// File: rtl/latch_bank.sv
module latch_bank
  import cfg_rx_pkg::*;
#(
  parameter int unsigned WORD_W   = 22,
  parameter int unsigned CHANNELS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit_i,
  input  logic [WORD_W-1:0]          word_i,
  output logic [CHANNELS*WORD_W-1:0] ref_o,
  output logic [CHANNELS*WORD_W-1:0] main_o,
  output logic [CHANNELS-1:0]        active_o
);
  localparam int unsigned SEL_W    = $clog2(2*CHANNELS);
  localparam int unsigned CH_IDX_W = SEL_W - 1;

  latch_kind_e kind;
  assign kind = latch_kind_e'(word_i[0]);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic              hit, ref_we, main_we;
    logic [WORD_W-1:0] ref_q, ref_d, main_q, main_d;
    logic              ref_seen_q, ref_seen_d, main_seen_q, main_seen_d;
    logic              act_q, act_d;

    always_comb begin
      hit         = commit_i && (word_i[SEL_W-1:1] == CH_IDX_W'(c));
      ref_we      = hit && (kind == LATCH_REF);
      main_we     = hit && (kind == LATCH_MAIN);
      ref_d       = ref_we  ? word_i : ref_q;
      main_d      = main_we ? word_i : main_q;
      ref_seen_d  = ref_seen_q  | ref_we;
      main_seen_d = main_seen_q | main_we;
      act_d       = ref_seen_d & main_seen_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q       <= '0;
        main_q      <= '0;
        ref_seen_q  <= 1'b0;
        main_seen_q <= 1'b0;
        act_q       <= 1'b0;
      end else begin
        ref_q       <= ref_d;
        main_q      <= main_d;
        ref_seen_q  <= ref_seen_d;
        main_seen_q <= main_seen_d;
        act_q       <= act_d;
      end
    end

    assign ref_o[c*WORD_W +: WORD_W]  = ref_q;
    assign main_o[c*WORD_W +: WORD_W] = main_q;
    assign active_o[c]                = act_q;
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int unsigned WORD_W   = CFG_WORD_W,
  parameter int unsigned CHANNELS = CFG_CHANNELS,
  parameter int unsigned SYNC_STG = CFG_SYNC_STG
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk_i,
  input  logic                       ser_data_i,
  input  logic                       ser_strobe_i,
  output logic [CHANNELS*WORD_W-1:0] ref_latch_o,
  output logic [CHANNELS*WORD_W-1:0] main_latch_o,
  output logic [CHANNELS-1:0]        chan_active_o
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic sclk_rise, sclk_lvl;
  logic data_lvl, data_rise;
  logic strobe_rise, strobe_lvl;
  logic [WORD_W-1:0] shift_word;
  logic have_bits, commit;

  sync_edge #(.STAGES(SYNC_STG)) u_sclk (
    .clk(clk), .rst_n(rst_sync_n), .async_i(ser_clk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise));

  sync_edge #(.STAGES(SYNC_STG)) u_data (
    .clk(clk), .rst_n(rst_sync_n), .async_i(ser_data_i),
    .level_o(data_lvl), .rise_o(data_rise));

  sync_edge #(.STAGES(SYNC_STG)) u_strobe (
    .clk(clk), .rst_n(rst_sync_n), .async_i(ser_strobe_i),
    .level_o(strobe_lvl), .rise_o(strobe_rise));

  shift_capture #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n),
    .shift_en_i(sclk_rise), .bit_i(data_lvl),
    .strobe_rise_i(strobe_rise),
    .word_o(shift_word), .have_bits_o(have_bits), .commit_o(commit));

  latch_bank #(.WORD_W(WORD_W), .CHANNELS(CHANNELS)) u_bank (
    .clk(clk), .rst_n(rst_sync_n),
    .commit_i(commit), .word_i(shift_word),
    .ref_o(ref_latch_o), .main_o(main_latch_o), .active_o(chan_active_o));

  // Levels and the data-edge pulse are not needed past the synchronizers
  logic unused_ok;
  assign unused_ok = ^{sclk_lvl, strobe_lvl, data_rise};
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk #(
  parameter int unsigned WORD_W   = 22,
  parameter int unsigned CHANNELS = 2
) (
  input logic                       clk,
  input logic                       rst_sync_n,
  input logic                       sclk_rise,
  input logic                       strobe_rise,
  input logic                       have_bits,
  input logic [WORD_W-1:0]          shift_word,
  input logic [CHANNELS*WORD_W-1:0] ref_latch_o,
  input logic [CHANNELS*WORD_W-1:0] main_latch_o,
  input logic [CHANNELS-1:0]        chan_active_o
);
  localparam int unsigned SEL_W = $clog2(2*CHANNELS);

  // Input assumption: serial clock and strobe edges never coincide (R2)
  a_r2_edges_apart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({sclk_rise, strobe_rise}));

  // R5: latches hold unless a strobe edge finds new bits
  a_r5_hold_without_transfer: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(strobe_rise && have_bits) |=> ($stable(ref_latch_o) && $stable(main_latch_o)));

  // R7: an empty strobe changes no active flag
  a_r7_empty_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_rise && !have_bits) |=> $stable(chan_active_o));

  for (genvar c = 0; c < CHANNELS; c++) begin : g_c
    // R4: the selected latch takes the input register
    a_r4_ref_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (strobe_rise && have_bits && !shift_word[0] && shift_word[SEL_W-1:1] == (SEL_W-1)'(c))
      |=> ref_latch_o[c*WORD_W +: WORD_W] == $past(shift_word));
    a_r4_main_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (strobe_rise && have_bits && shift_word[0] && shift_word[SEL_W-1:1] == (SEL_W-1)'(c))
      |=> main_latch_o[c*WORD_W +: WORD_W] == $past(shift_word));
    // R6: once active, a channel stays active until reset
    a_r6_active_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
      chan_active_o[c] |=> chan_active_o[c]);
  end
endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(.WORD_W(WORD_W), .CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .sclk_rise(sclk_rise),
  .strobe_rise(strobe_rise), .have_bits(have_bits), .shift_word(shift_word),
  .ref_latch_o(ref_latch_o), .main_latch_o(main_latch_o),
  .chan_active_o(chan_active_o));

// File: tb/tb_cfg_serial_rx.sv
module tb_cfg_serial_rx;
  localparam int W = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [2*W-1:0] ref_o, main_o;
  logic [1:0]     act_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model
  logic [W-1:0] m_shift;
  logic [W-1:0] m_ref [2];
  logic [W-1:0] m_main[2];
  logic [1:0]   m_rseen, m_mseen;
  int           m_nbits;

  always #5 clk = ~clk;

  cfg_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
    .ser_strobe_i(sle), .ref_latch_o(ref_o), .main_latch_o(main_o),
    .chan_active_o(act_o));

  // {bit count, data sent most significant first}
  localparam logic [28:0] VEC [6] = '{
    {5'd22, 24'h0ABCD0},   // R4 code 00
    {5'd24, 24'hFF1235},   // R3 code 01, two leading bits dropped
    {5'd24, 24'hC2468A},   // R3 code 10
    {5'd22, 24'h155557},   // R4 code 11
    {5'd24, 24'h800004},   // R3 overwrite code 00
    {5'd22, 24'h3FFFFF}    // R4 overwrite code 11
  };

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_shift = '0; m_nbits = 0; m_rseen = '0; m_mseen = '0;
    for (int c = 0; c < 2; c++) begin m_ref[c] = '0; m_main[c] = '0; end
  endtask

  task automatic send_bits(input logic [23:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdata = d[i];
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
      repeat (3) @(negedge clk);
      m_shift = {m_shift[W-2:0], d[i]};
      m_nbits++;
    end
  endtask

  task automatic strobe();
    @(negedge clk); sle = 1'b1;
    repeat (4) @(negedge clk); sle = 1'b0;
    repeat (8) @(negedge clk);
    if (m_nbits > 0) begin
      if (m_shift[0]) begin m_main[m_shift[1]] = m_shift; m_mseen[m_shift[1]] = 1'b1; end
      else            begin m_ref[m_shift[1]]  = m_shift; m_rseen[m_shift[1]] = 1'b1; end
    end
    m_nbits = 0;
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 2; c++) begin
      check(req, $sformatf("ch%0d ref", c),  ref_o[c*W +: W],  m_ref[c]);
      check(req, $sformatf("ch%0d main", c), main_o[c*W +: W], m_main[c]);
      check("R6", $sformatf("ch%0d active", c), W'(act_o[c]),
            W'(m_rseen[c] & m_mseen[c]));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sclk = 1'b0; sle = 1'b0; sdata = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    check_all("R1");              // R1 while reset held
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_all("R1");              // R1 after release
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    do_reset();

    // Table walk: R2, R3, R4, R5, R6
    for (int v = 0; v < 6; v++) begin
      send_bits(VEC[v][23:0], int'(VEC[v][28:24]));
      strobe();
      check_all((v == 1 || v == 2 || v == 4) ? "R3" : "R4");
      check("R5", "sum of untouched", ref_o[W-1:0] ^ main_o[W-1:0] ^
            ref_o[2*W-1:W] ^ main_o[2*W-1:W],
            m_ref[0] ^ m_main[0] ^ m_ref[1] ^ m_main[1]);
    end

    // R7: strobe with no new bits leaves everything alone
    strobe();
    check_all("R7");

    // R8: two new bits reuse older bits; word becomes {prev[19:0], 2'b10}
    send_bits(24'h000002, 2);
    strobe();
    check_all("R8");
    check("R8", "ch1 ref explicit", ref_o[2*W-1:W], {22'h3FFFFF} << 2 | 22'h2);

    // R1 again, then R6: only channel 1 fully written
    do_reset();
    send_bits(24'h000002, 22); strobe();   // code 10: ch1 ref
    check_all("R6");
    send_bits(24'h000001, 22); strobe();   // code 01: ch0 main only
    check_all("R6");
    send_bits(24'h012343, 22); strobe();   // code 11: ch1 main
    check_all("R6");
    check("R6", "ch0 still inactive", W'(act_o[0]), '0);
    check("R6", "ch1 active", W'(act_o[1]), W'(1));

    // R2: falling serial-clock edges do not shift (register unchanged by hold)
    repeat (20) @(negedge clk);
    strobe();                                // no new rising edges: ignored
    check_all("R2");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule